// File: doc/BRIEF.md
# Three-Stage CAN Receive Queue

This block holds CAN frames that have already passed acceptance filtering, until software takes them. Up to three frames are kept in arrival order. Each holds an identifier (standard or extended), remote flag, data length code, 16-bit capture timestamp and eight data bytes. The oldest frame is always visible in a read-only mailbox of four 32-bit words. Software reads the mailbox and then writes a one to the release bit of the queue control word. That drops the oldest frame and brings the next one forward.

The block reports a pending count and two sticky flags: queue-full and overrun. Both flags are cleared by writing ones to their bits. A lock input sets the overrun policy. With lock set, a frame that arrives into a full queue is thrown away. With lock clear, it replaces the most recently stored frame. One interrupt line combines three separately enabled sources: frame pending, full and overrun. A controller with two receive queues instantiates this block twice, once per interrupt line.

Top module: `can_rx_fifo`

## Requirements
- R1: After reset the pending count is 0, both flags are 0 and the interrupt is low. While the queue is empty, all four mailbox words read as zero.
- R2: Each frame offered on `inValid` while fewer than three are stored is kept. `pendCount` gives the number stored (0 to 3). The mailbox shows the oldest stored frame, so frames leave in arrival order.
- R3: A control write with bit 5 set removes the frame in the mailbox and shows the next one. On an empty queue it has no effect.
- R4: Mailbox identifier word. For a standard frame, bits 31:21 hold the 11-bit identifier. For an extended frame, bits 31:3 hold the 29-bit identifier and bit 2 is one. Bit 1 is the remote flag. All other bits are zero.
- R5: Mailbox length word: bits 31:16 hold the timestamp, bits 3:0 the data length code, and the rest read zero. The data words hold bytes 0-3 (low word) and 4-7 (high word), byte 0 in bits 7:0.
- R6: The full flag (bit 3) sets in the cycle the count reaches three. It stays set until a control write with bit 3 set clears it. A new setting event wins over a clear in the same cycle.
- R7: The overrun flag (bit 4) sets when a frame arrives while three are stored and no release happens in that cycle. It stays set until a control write with bit 4 set clears it.
- R8: With `lockOnOverrun` high, a frame that arrives into a full queue is discarded. The count stays three and the stored frames are unchanged.
- R9: With `lockOnOverrun` low, a frame that arrives into a full queue replaces the newest stored frame. The two older frames and the count stay as they were.
- R10: A release and an arrival in the same cycle on a full queue take the oldest frame out and store the new one. The count stays three and no overrun is flagged.
- R11: `rxIrq` is the OR of three terms: `irqEnable[0]` with a nonzero count, `irqEnable[1]` with the full flag, and `irqEnable[2]` with the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | One-cycle strobe: a filtered frame is offered |
| inId | input | 29 | Identifier; a standard frame uses bits 10:0 |
| inExt | input | 1 | Frame uses an extended identifier |
| inRtr | input | 1 | Remote frame |
| inDlc | input | 4 | Data length code |
| inStamp | input | 16 | Capture timestamp |
| inData | input | 64 | Data bytes, byte 0 in bits 7:0 |
| lockOnOverrun | input | 1 | 1: discard on overrun; 0: overwrite newest |
| regWrEn | input | 1 | Write strobe for the queue control word |
| regWrData | input | 32 | Control word: bit 5 release, bit 3 clear full, bit 4 clear overrun |
| irqEnable | input | 3 | Interrupt enables: 0 pending, 1 full, 2 overrun |
| mbId | output | 32 | Mailbox identifier word |
| mbLen | output | 32 | Mailbox timestamp and length word |
| mbDataLo | output | 32 | Mailbox data bytes 0-3 |
| mbDataHi | output | 32 | Mailbox data bytes 4-7 |
| pendCount | output | CNT_W | Frames stored |
| fullFlag | output | 1 | Sticky queue-full flag |
| ovrFlag | output | 1 | Sticky overrun flag |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The bench sweeps every fill depth from zero to five arrivals under both overrun policies and all eight interrupt-enable patterns, then drains the queue. A reference queue in the bench predicts every mailbox word after each step.

- Mixing up the policies would make a locked queue lose its newest frame, or an unlocked one keep a stale frame.
- Overwriting the wrong slot would corrupt the oldest frame, which software reads first.
- A release-plus-arrival on a full queue is aimed at a design that checks fullness before the release. Such a design would drop the frame and raise a false overrun.
- Releases on an empty queue catch a count that wraps to three.
- Clearing the full flag while the queue stays full catches a flag that is re-derived from the count instead of held sticky.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

  // Widest queue index the strobe struct can carry (queues up to 16 stages).
  localparam int PTR_W_MAX = 4;

  // Control word bit positions decoded by this block.
  localparam int CLR_FULL_BIT = 3;
  localparam int CLR_OVR_BIT  = 4;
  localparam int RELEASE_BIT  = 5;

  // Interrupt enable positions.
  localparam int IE_PEND = 0;
  localparam int IE_FULL = 1;
  localparam int IE_OVR  = 2;

  typedef struct packed {
    logic [28:0] id;
    logic        ext;
    logic        rtr;
    logic [3:0]  dlc;
    logic [15:0] stamp;
    logic [63:0] data;
  } rxFrame_t;

  // Strobes from the control to the frame store.
  typedef struct packed {
    logic                 wrEn;
    logic [PTR_W_MAX-1:0] wrIdx;
    logic [PTR_W_MAX-1:0] rdIdx;
    logic                 show;
  } storeCtl_t;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             lockOnOverrun,
  input  logic             relReq,
  input  logic             clrFull,
  input  logic             clrOvr,
  output storeCtl_t        ctl,
  output logic [CNT_W-1:0] pendCount,
  output logic             fullFlag,
  output logic             ovrFlag
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W_MAX-1:0] LAST_IDX = PTR_W_MAX'(DEPTH - 1);

  logic [PTR_W_MAX-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0]     cntQ, cntAfterPop, cntNext;
  logic                 doPop, doPush, doOver, doOverwrite, fullSet;

  function automatic logic [PTR_W_MAX-1:0] ptrInc(input logic [PTR_W_MAX-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W_MAX-1:0] ptrDec(input logic [PTR_W_MAX-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  // A release in the same cycle frees a stage before the arrival is judged.
  always_comb begin
    doPop       = relReq && (cntQ != '0);
    cntAfterPop = cntQ - CNT_W'(doPop);
    doPush      = inValid && (cntAfterPop != DEPTH_C);
    doOver      = inValid && (cntAfterPop == DEPTH_C);
    doOverwrite = doOver && !lockOnOverrun;
    fullSet     = doPush && ((cntAfterPop + 1'b1) == DEPTH_C);
    cntNext     = cntAfterPop + CNT_W'(doPush);

    ctl.wrEn  = doPush || doOverwrite;
    ctl.wrIdx = doPush ? tailPtr : ptrDec(tailPtr);
    ctl.rdIdx = headPtr;
    ctl.show  = (cntQ != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      cntQ     <= '0;
      fullFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end else begin
      if (doPop)  headPtr <= ptrInc(headPtr);
      if (doPush) tailPtr <= ptrInc(tailPtr);
      cntQ <= cntNext;
      if (fullSet)      fullFlag <= 1'b1;
      else if (clrFull) fullFlag <= 1'b0;
      if (doOver)       ovrFlag <= 1'b1;
      else if (clrOvr)  ovrFlag <= 1'b0;
    end
  end

  assign pendCount = cntQ;

endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  storeCtl_t   ctl,
  input  rxFrame_t    wrFrame,
  output logic [31:0] mbId,
  output logic [31:0] mbLen,
  output logic [31:0] mbDataLo,
  output logic [31:0] mbDataHi
);

  rxFrame_t slotQ [DEPTH];
  rxFrame_t headFrame;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slotQ[s] <= '0;
      else if (ctl.wrEn && (ctl.wrIdx == PTR_W_MAX'(s)))
        slotQ[s] <= wrFrame;
    end
  end

  always_comb begin
    headFrame = '0;
    for (int s = 0; s < DEPTH; s++)
      if (ctl.rdIdx == PTR_W_MAX'(s)) headFrame = slotQ[s];
  end

  // Mailbox word layout; all zero while nothing is pending.
  always_comb begin
    mbId     = '0;
    mbLen    = '0;
    mbDataLo = '0;
    mbDataHi = '0;
    if (ctl.show) begin
      if (headFrame.ext)
        mbId = {headFrame.id, 1'b1, headFrame.rtr, 1'b0};
      else
        mbId = {headFrame.id[10:0], 18'd0, 1'b0, headFrame.rtr, 1'b0};
      mbLen    = {headFrame.stamp, 12'd0, headFrame.dlc};
      mbDataLo = headFrame.data[31:0];
      mbDataHi = headFrame.data[63:32];
    end
  end

endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [28:0]      inId,
  input  logic             inExt,
  input  logic             inRtr,
  input  logic [3:0]       inDlc,
  input  logic [15:0]      inStamp,
  input  logic [63:0]      inData,
  input  logic             lockOnOverrun,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  input  logic [2:0]       irqEnable,
  output logic [31:0]      mbId,
  output logic [31:0]      mbLen,
  output logic [31:0]      mbDataLo,
  output logic [31:0]      mbDataHi,
  output logic [CNT_W-1:0] pendCount,
  output logic             fullFlag,
  output logic             ovrFlag,
  output logic             rxIrq
);

  storeCtl_t ctl;
  rxFrame_t  wrFrame;

  assign wrFrame = '{id: inId, ext: inExt, rtr: inRtr, dlc: inDlc,
                     stamp: inStamp, data: inData};

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .inValid       (inValid),
    .lockOnOverrun (lockOnOverrun),
    .relReq        (regWrEn && regWrData[RELEASE_BIT]),
    .clrFull       (regWrEn && regWrData[CLR_FULL_BIT]),
    .clrOvr        (regWrEn && regWrData[CLR_OVR_BIT]),
    .ctl           (ctl),
    .pendCount     (pendCount),
    .fullFlag      (fullFlag),
    .ovrFlag       (ovrFlag)
  );

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .wrFrame  (wrFrame),
    .mbId     (mbId),
    .mbLen    (mbLen),
    .mbDataLo (mbDataLo),
    .mbDataHi (mbDataHi)
  );

  assign rxIrq = (irqEnable[IE_PEND] && (pendCount != '0)) ||
                 (irqEnable[IE_FULL] && fullFlag) ||
                 (irqEnable[IE_OVR]  && ovrFlag);

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             lockOnOverrun,
  input logic             regWrEn,
  input logic [31:0]      regWrData,
  input logic [2:0]       irqEnable,
  input logic [31:0]      mbId,
  input logic [31:0]      mbLen,
  input logic [CNT_W-1:0] pendCount,
  input logic             fullFlag,
  input logic             ovrFlag,
  input logic             rxIrq
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  logic relNow;
  assign relNow = regWrEn && regWrData[5];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pendCount <= DEPTH_C);

  assert_empty_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (relNow && pendCount == '0 && !inValid) |=> pendCount == '0);

  assert_empty_mailbox_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pendCount == '0) |-> (mbId == '0 && mbLen == '0));

  assert_full_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !relNow && pendCount == DEPTH_C - 1'b1) |=> fullFlag);

  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !relNow && pendCount == DEPTH_C) |=> (ovrFlag && pendCount == DEPTH_C));

  assert_lock_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && lockOnOverrun && !relNow && pendCount == DEPTH_C)
      |=> ($stable(mbId) && $stable(mbLen)));

  assert_swap_no_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && relNow && pendCount == DEPTH_C && !ovrFlag) |=> (!ovrFlag && pendCount == DEPTH_C));

  assert_irq_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irqEnable[0] && pendCount != '0) |-> rxIrq);

endmodule

bind can_rx_fifo rxf_checker #(.DEPTH(DEPTH)) u_rxf_checker (.*);

// File: tb/tb_can_rx_fifo.sv
module tb_can_rx_fifo;

  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [28:0] inId = '0;
  logic        inExt = 1'b0;
  logic        inRtr = 1'b0;
  logic [3:0]  inDlc = '0;
  logic [15:0] inStamp = '0;
  logic [63:0] inData = '0;
  logic        lockOnOverrun = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [2:0]  irqEnable = '0;
  logic [31:0] mbId, mbLen, mbDataLo, mbDataHi;
  logic [1:0]  pendCount;
  logic        fullFlag, ovrFlag, rxIrq;

  can_rx_fifo #(.DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inId(inId), .inExt(inExt),
    .inRtr(inRtr), .inDlc(inDlc), .inStamp(inStamp), .inData(inData),
    .lockOnOverrun(lockOnOverrun), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqEnable(irqEnable), .mbId(mbId), .mbLen(mbLen), .mbDataLo(mbDataLo),
    .mbDataHi(mbDataHi), .pendCount(pendCount), .fullFlag(fullFlag),
    .ovrFlag(ovrFlag), .rxIrq(rxIrq)
  );

  always #4 clk = ~clk;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  // Reference queue holds frame indices.
  int mQ [D];
  int mCnt = 0;
  bit mFull = 0;
  bit mOvr = 0;

  function automatic logic [28:0] fId(int k);
    return 29'(k * 32'h0135_79BD + 32'h0ABC);
  endfunction
  function automatic bit fExt(int k);  return k[0]; endfunction
  function automatic bit fRtr(int k);  return (k % 3) == 0; endfunction
  function automatic logic [3:0] fDlc(int k);  return 4'(k % 9); endfunction
  function automatic logic [15:0] fStamp(int k); return 16'(k * 1000 + 7); endfunction
  function automatic logic [63:0] fData(int k);
    return {8{8'(k)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [31:0] expId(int k);
    logic [31:0] r;
    if (fExt(k)) r = ({3'b000, fId(k)} << 3) | 32'd4;
    else         r = {21'd0, fId(k)[10:0]} << 21;
    return r | (32'(fRtr(k)) << 1);
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic checkAll(string ctx);
    int k;
    bit irqExp;
    k = mQ[0];
    irqExp = (irqEnable[0] && mCnt > 0) || (irqEnable[1] && mFull) || (irqEnable[2] && mOvr);
    chk({ctx, " R2 count"}, 32'(pendCount), 32'(mCnt));
    chk({ctx, " R6 full"}, 32'(fullFlag), 32'(mFull));
    chk({ctx, " R7 overrun"}, 32'(ovrFlag), 32'(mOvr));
    chk({ctx, " R11 irq"}, 32'(rxIrq), 32'(irqExp));
    chk({ctx, " R4 id word"}, mbId, mCnt > 0 ? expId(k) : 32'd0);
    chk({ctx, " R5 len word"}, mbLen,
        mCnt > 0 ? {fStamp(k), 12'd0, fDlc(k)} : 32'd0);
    chk({ctx, " R5 data lo"}, mbDataLo, mCnt > 0 ? fData(k)[31:0] : 32'd0);
    chk({ctx, " R5 data hi"}, mbDataHi, mCnt > 0 ? fData(k)[63:32] : 32'd0);
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(string ctx, bit push, int k, bit rel, bit clrF, bit clrO);
    bit fullSet, ovrSet;
    inValid   = push;
    inId      = fId(k);
    inExt     = fExt(k);
    inRtr     = fRtr(k);
    inDlc     = fDlc(k);
    inStamp   = fStamp(k);
    inData    = fData(k);
    regWrEn   = rel || clrF || clrO;
    regWrData = (32'(rel) << 5) | (32'(clrF) << 3) | (32'(clrO) << 4);
    @(posedge clk);
    fullSet = 0;
    ovrSet  = 0;
    if (rel && mCnt > 0) begin
      for (int i = 0; i < D - 1; i++) mQ[i] = mQ[i + 1];
      mCnt--;
    end
    if (push) begin
      if (mCnt < D) begin
        mQ[mCnt] = k;
        mCnt++;
        if (mCnt == D) fullSet = 1;
      end else begin
        ovrSet = 1;
        if (!lockOnOverrun) mQ[D - 1] = k;
      end
    end
    mFull = fullSet || (mFull && !clrF);
    mOvr  = ovrSet || (mOvr && !clrO);
    @(negedge clk);
    inValid   = 1'b0;
    regWrEn   = 1'b0;
    regWrData = '0;
    checkAll(ctx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int kk;
    kk = 1;
    for (int i = 0; i < D; i++) mQ[i] = 0;
    irqEnable = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    for (int lk = 0; lk < 2; lk++) begin
      for (int n = 0; n <= 5; n++) begin
        lockOnOverrun = lk[0];
        irqEnable = 3'((lk * 6 + n) % 8);
        for (int i = 0; i < n; i++) begin
          step(i >= D ? (lk != 0 ? "R8 locked arrival" : "R9 overwrite arrival")
                      : "R2 fill", 1, kk, 0, 0, 0);
          kk++;
        end
        step("R6 clear full", 0, 0, 0, 1, 0);
        step("R7 clear overrun", 0, 0, 0, 0, 1);
        if (mCnt == D) begin
          step("R10 release with arrival", 1, kk, 1, 0, 0);
          kk++;
        end
        while (mCnt > 0) step("R3 release", 0, 0, 1, 0, 0);
        step("R3 release when empty", 0, 0, 1, 0, 0);
        step("R1 empty after flags cleared", 0, 0, 0, 1, 1);
      end
    end

    // Full flag set and clear in the same cycle: set wins.
    lockOnOverrun = 1'b1;
    irqEnable = 3'b010;
    step("R2 fill", 1, kk, 0, 0, 0); kk++;
    step("R2 fill", 1, kk, 0, 0, 0); kk++;
    step("R6 set beats clear", 1, kk, 0, 1, 0); kk++;
    step("R7 overrun", 1, kk, 0, 0, 0); kk++;
    while (mCnt > 0) step("R3 release", 0, 0, 1, 0, 0);
    step("R11 flags cleared", 0, 0, 0, 1, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule